// File: doc/BRIEF.md
# Peripheral E-Clock Generator and Bus Cycle Synchroniser

This block sits beside a processor that runs faster than its slow peripherals expect. It derives a free-running phase-2 style clock, called E here, from the input clock. E runs at a steady rate whatever the bus is doing. With the default divide of ten input clocks, E comes out near 714 kHz.

When the processor starts a slow-peripheral cycle, it raises its address strobe together with a slow-peripheral select. The block then holds the processor off by withholding its transfer acknowledge. It lets the cycle run for one whole E period, starting at the next period boundary. It raises the acknowledge in the last input clock of that period's E-high phase, so the access ends in step with E. An enable window marks, for the peripheral side, the E period that belongs to the access.

Top module: `eclk_sync_ctrl`

## Requirements
- R1: `eclk_o` toggles without pause at one fixed period of `DIV` input clocks. Each period starts with the low phase. Bus activity never stretches, shortens or restarts a period.
- R2: The low phase lasts `floor(DIV*6/10)` clocks and the high phase takes the remaining clocks. With `DIV`=10 that is 6 low and 4 high.
- R3: A request is both `strobe_i` and `slow_sel_i` high at a rising clock edge. The request is served in the first E period that begins after that edge, including a period that begins on the very next clock.
- R4: Service never starts within a period that is already running. `pen_o` rises only in the first low clock of a period, even for a request made while E is high.
- R5: `pen_o` is high for every clock of the serviced period. It goes low in the clock in which E falls at the end of that period.
- R6: `ack_o` first rises in the last E-high clock of the serviced period. In that clock it is high only if `strobe_i` is high.
- R7: Once raised, `ack_o` stays high for as long as `strobe_i` stays high. It goes low in the same clock as `strobe_i`.
- R8: If `strobe_i` falls before the acknowledge clock, the request is dropped. `pen_o` goes low on the next clock and no acknowledge is given for that request.
- R9: `strobe_i` high with `slow_sel_i` low is not a request. It leaves `pen_o` and `ack_o` low.
- R10: A synchronous active-high `rst_i` puts E at the first clock of its low phase and returns the controller to idle. `pen_o` and `ack_o` are low in the clock after any reset edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_i | input | 1 | Synchronous reset, active high |
| strobe_i | input | 1 | Processor address strobe, active high |
| slow_sel_i | input | 1 | Slow-peripheral cycle select, active high |
| eclk_o | output | 1 | Free-running E clock |
| pen_o | output | 1 | Peripheral enable window for the serviced E period |
| ack_o | output | 1 | Transfer acknowledge to the processor, active high |

## Verification
Two events can fall in the same clock. The acknowledge clock of a serviced period can coincide with the processor withdrawing its strobe. A new request can arrive in the final clock of a period, so it is accepted in the same edge as the counter wraps. The bench provokes both by timing strobe changes against its own model of the E phase: one request is made at the last clock of a period, and one strobe is dropped exactly in the clock where the acknowledge would first appear. A cycle-by-cycle model then judges whether the enable started at the boundary and whether the acknowledge was suppressed.

// File: rtl/eclk_pkg.sv
package eclk_pkg;

  typedef enum logic [1:0] {
    BUS_IDLE,
    BUS_WAIT,
    BUS_SERVE,
    BUS_HOLD
  } bus_state_e;

  // Length of the E-low phase: first 60% of the period, rounded down.
  function automatic int unsigned e_low_len(input int unsigned div);
    return (div * 6) / 10;
  endfunction

endpackage

// File: rtl/eclk_phase_gen.sv
module eclk_phase_gen
  import eclk_pkg::*;
#(
  parameter int unsigned DIV = 10
) (
  input  logic clk_i,
  input  logic rst_i,
  output logic eclk_o,
  output logic first_o,
  output logic last_o
);

  localparam int unsigned CW      = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int unsigned LOW_LEN = e_low_len(DIV);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q <= '0;
    end else if (cnt_q == CW'(DIV - 1)) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign eclk_o  = (cnt_q >= CW'(LOW_LEN));
  assign first_o = (cnt_q == '0);
  assign last_o  = (cnt_q == CW'(DIV - 1));

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
    cnt_q < CW'(DIV)); // R1
  AST_E_RISE_POS: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(eclk_o) |-> $past(cnt_q) == CW'(LOW_LEN - 1)); // R2

endmodule

// File: rtl/eclk_bus_sync.sv
module eclk_bus_sync
  import eclk_pkg::*;
(
  input  logic clk_i,
  input  logic rst_i,
  input  logic strobe_i,
  input  logic slow_sel_i,
  input  logic eclk_i,
  input  logic first_i,
  input  logic last_i,
  output logic pen_o,
  output logic ack_o
);

  bus_state_e state_q, state_d;
  logic       req_seen;

  assign req_seen = strobe_i && slow_sel_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      BUS_IDLE: begin
        if (req_seen) state_d = last_i ? BUS_SERVE : BUS_WAIT;
      end
      BUS_WAIT: begin
        if (!strobe_i)   state_d = BUS_IDLE;
        else if (last_i) state_d = BUS_SERVE;
      end
      BUS_SERVE: begin
        if (!strobe_i)   state_d = BUS_IDLE;
        else if (last_i) state_d = BUS_HOLD;
      end
      BUS_HOLD: begin
        if (!strobe_i)   state_d = BUS_IDLE;
      end
      default: state_d = BUS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) state_q <= BUS_IDLE;
    else       state_q <= state_d;
  end

  assign pen_o = (state_q == BUS_SERVE);
  assign ack_o = strobe_i && (((state_q == BUS_SERVE) && last_i) || (state_q == BUS_HOLD));

  AST_PEN_START: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(pen_o) |-> first_i); // R4
  AST_PEN_END: assert property (@(posedge clk_i) disable iff (rst_i)
    (pen_o && last_i) |=> !pen_o); // R5
  AST_ACK_E_HIGH: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(ack_o) |-> (eclk_i && last_i)); // R6
  AST_ACK_HELD: assert property (@(posedge clk_i) disable iff (rst_i)
    (ack_o && strobe_i) |=> (ack_o || !strobe_i)); // R7
  AST_DROP_REQ: assert property (@(posedge clk_i) disable iff (rst_i)
    ((state_q == BUS_WAIT || state_q == BUS_SERVE) && !strobe_i) |=> !pen_o); // R8
  AST_IGNORE_NOSEL: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_q == BUS_IDLE && strobe_i && !slow_sel_i) |=> (state_q == BUS_IDLE)); // R9

endmodule

// File: rtl/eclk_sync_ctrl.sv
module eclk_sync_ctrl
  import eclk_pkg::*;
#(
  parameter int unsigned DIV = 10
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic strobe_i,
  input  logic slow_sel_i,
  output logic eclk_o,
  output logic pen_o,
  output logic ack_o
);

  // Phase events brought out for the controller and the assertions.
  logic phase_first;
  logic phase_last;

  eclk_phase_gen #(.DIV(DIV)) u_phase (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .eclk_o  (eclk_o),
    .first_o (phase_first),
    .last_o  (phase_last)
  );

  eclk_bus_sync u_sync (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .strobe_i   (strobe_i),
    .slow_sel_i (slow_sel_i),
    .eclk_i     (eclk_o),
    .first_i    (phase_first),
    .last_i     (phase_last),
    .pen_o      (pen_o),
    .ack_o      (ack_o)
  );

  AST_E_WRAP_LOW: assert property (@(posedge clk_i) disable iff (rst_i)
    phase_last |=> !eclk_o); // R1
  AST_RST_QUIET: assert property (@(posedge clk_i)
    rst_i |=> (!pen_o && !ack_o && !eclk_o)); // R10

endmodule

// File: tb/eclk_sync_ctrl_tb.sv
module eclk_sync_ctrl_tb;

  localparam int CLK_P = 10;
  localparam int DIV   = 10;
  localparam int HI    = (DIV * 4 + 9) / 10;  // high clocks, rounded up

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic strobe = 1'b0;
  logic sel = 1'b0;
  logic e, pen, ack;

  always #(CLK_P / 2) clk = ~clk;

  eclk_sync_ctrl #(.DIV(DIV)) u_dut (
    .clk_i      (clk),
    .rst_i      (rst),
    .strobe_i   (strobe),
    .slow_sel_i (sel),
    .eclk_o     (e),
    .pen_o      (pen),
    .ack_o      (ack)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  string tag = "R10";
  bit    seen = 1'b0;

  // Reference model: absolute clock count since reset, served period number.
  longint t = 0;
  longint target = -1;
  bit     acked = 1'b0;

  always @(posedge clk) begin
    seen = 1'b1;
    if (rst) begin
      t = 0; target = -1; acked = 1'b0;
    end else begin
      if (acked) begin
        if (!strobe) acked = 1'b0;
      end else if (target < 0) begin
        if (strobe && sel) target = t / DIV + 1;
      end else if (!strobe) begin
        target = -1;
      end else if ((t % DIV) == DIV - 1 && (t / DIV) == target) begin
        acked = 1'b1; target = -1;
      end
      t++;
    end
  end

  function automatic bit exp_e();
    return (t % DIV) >= (DIV - HI);
  endfunction
  function automatic bit exp_pen();
    return (target >= 0) && ((t / DIV) == target);
  endfunction
  function automatic bit exp_ack();
    return strobe && (acked || (exp_pen() && (t % DIV) == DIV - 1));
  endfunction

  task automatic chk(input string what, input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b (t=%0d)", req, what, act, exp, t);
    end
  endtask

  task automatic chk_int(input string what, input string req, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (seen) begin
      chk("eclk", "R1", e, exp_e());
      chk("enable", tag, pen, exp_pen());
      chk("ack", tag, ack, exp_ack());
    end
  end

  task automatic step1();
    @(posedge clk); #1;
  endtask
  task automatic step(input int n);
    for (int i = 0; i < n; i++) step1();
  endtask
  task automatic wait_pos(input int p);
    step1();
    while ((t % DIV) != p) step1();
  endtask

  task automatic access(input int p, input int hold);
    longint t_req, t_pen;
    wait_pos(p);
    t_req = t; t_pen = -1;
    strobe = 1'b1; sel = 1'b1;
    for (int k = 0; k < 4 * DIV && ack !== 1'b1; k++) begin
      step1();
      if (pen === 1'b1 && t_pen < 0) t_pen = t;
    end
    chk_int("enable start clock", "R3", t_pen, (t_req / DIV + 1) * DIV);
    chk_int("enable start phase", "R4", t_pen % DIV, 0);
    chk_int("ack phase", "R6", t % DIV, DIV - 1);
    chk("ack with E high", "R6", e, 1'b1);
    step(hold);
    strobe = 1'b0; sel = 1'b0;
    step(3);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int hi_cnt;
    tag = "R10";
    step(3);
    rst = 1'b0;
    tag = "R1";
    step(25);

    hi_cnt = 0;
    for (int i = 0; i < DIV; i++) begin
      step1();
      if (e === 1'b1) hi_cnt++;
    end
    chk_int("E high clocks per period", "R2", hi_cnt, HI);

    tag = "R9";
    strobe = 1'b1; sel = 1'b0;
    step(2 * DIV);
    strobe = 1'b0;
    step(2);

    tag = "R5"; access(2, 0);
    tag = "R6"; access(7, 2);
    tag = "R3"; access(DIV - 1, 1);
    tag = "R4"; access(0, 0);
    tag = "R7"; access(4, 6);
    tag = "R3"; access(5, 0);

    // R8: strobe withdrawn while waiting for the period boundary
    tag = "R8";
    wait_pos(3);
    strobe = 1'b1; sel = 1'b1;
    step(4);
    strobe = 1'b0; sel = 1'b0;
    step(2 * DIV);

    // R8: strobe withdrawn inside the serviced period
    wait_pos(5);
    strobe = 1'b1; sel = 1'b1;
    for (int k = 0; k < 3 * DIV && pen !== 1'b1; k++) step1();
    step(3);
    strobe = 1'b0; sel = 1'b0;
    step(2 * DIV);

    // R6: strobe withdrawn in the very clock the acknowledge would appear
    tag = "R6";
    wait_pos(1);
    strobe = 1'b1; sel = 1'b1;
    for (int k = 0; k < 3 * DIV && !(((t % DIV) == DIV - 1) && exp_pen()); k++) step1();
    strobe = 1'b0; sel = 1'b0;
    step(2 * DIV);

    // R10: reset in the middle of a serviced period
    tag = "R10";
    wait_pos(2);
    strobe = 1'b1; sel = 1'b1;
    for (int k = 0; k < 3 * DIV && pen !== 1'b1; k++) step1();
    step(2);
    rst = 1'b1;
    step(2);
    rst = 1'b0; strobe = 1'b0; sel = 1'b0;
    step(2 * DIV);

    tag = "R5"; access(6, 1);

    summary();
    $finish;
  end

endmodule